// File: doc/BRIEF.md
# SMM Memory Steering Controller

This block sits on the system side of a processor that has a system management mode (SMM). It decides, for every bus cycle, whether the access goes to the protected SMM memory or to ordinary main memory. It also drives the cache-control lines so that the processor caches never return data from the wrong space across an SMM entry or exit. These lines are the flush request, the cache-enable line and the write-back/write-through selector. It also masks the address-bit-20 force request while the processor is inside SMM.

The SMM region is a 32 KiB window. Its base resets to 38000h with the window overlaid on main memory, and a one-cycle load port can move it or switch it to a private, non-overlaid space. In write-through systems the flush follows the SMM-active status edges. In write-back systems it follows the SMI request, and caching inside SMM is then forced to write-through or switched off. The SMI, SMM-active and A20 request inputs are resynchronised before any edge is taken from them.

Top module: `smm_steer`

## Requirements
- R1: After reset `flush_n` is 1, `ken_n` is 0, `a20m_n` is 1 and `wbwt` equals `wb_mode`.
- R2: With overlay enabled, a strobed CPU cycle (`cyc_mid` = 0) whose address lies in the window [base, base+7FFFh] asserts `smram_cs` when `smiact_n` is 0 and `dram_cs` when it is 1. No chip select is asserted without `cyc_stb`. The two selects are never asserted together.
- R3: A strobed cycle from any master other than the CPU never asserts `smram_cs`. With overlay enabled, such a cycle selects `dram_cs` even inside the window.
- R4: In write-through mode (`wb_mode` = 0) with overlay enabled, a falling edge on `smiact_n` gives `flush_n` = 0 for exactly one cycle, four clock edges after the change.
- R5: In write-through mode with `cache_keep` = 1, a rising edge on `smiact_n` gives a second single-cycle flush pulse with the same four-edge latency.
- R6: With `cache_keep` = 0, `ken_n` goes to 1 three edges after the SMM entry edge and returns to 0 three edges after the `smiact_n` rising edge. No exit flush is produced.
- R7: In write-back mode (`wb_mode` = 1) the flush pulse follows a falling edge on `smi_n` by four edges, and a falling edge on `smiact_n` alone gives none. `wbwt` goes to 0 three edges after SMI and returns to 1 three edges after `smiact_n` rises.
- R8: `a20m_n` follows `a20m_req_n` two edges late. It is held at 1 from two edges after `smiact_n` falls until three edges after `smiact_n` rises.
- R9: With overlay disabled, no flush pulses are produced. A CPU cycle in the window with `smiact_n` = 0 selects `smram_cs`. Any other cycle in the window selects neither memory. Cycles outside the window select `dram_cs`.
- R10: A flush request that arrives while a pulse is outstanding is queued. Two requests one cycle apart give two low pulses, at edges four and six, with a high cycle between them.
- R11: The window base and overlay bit reset to 38000h and overlaid. A load through `cfg_we` takes effect on decode from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smi_n | input | 1 | SMI request toward the processor, active low |
| smiact_n | input | 1 | SMM active status from the processor, active low |
| a20m_req_n | input | 1 | Raw address-bit-20 force request, active low |
| cyc_stb | input | 1 | Bus cycle valid strobe |
| cyc_addr | input | ADDR_W | Bus cycle address |
| cyc_mid | input | MID_W | Bus master identifier, CPU_ID for the processor |
| wb_mode | input | 1 | Cache mode strap, 1 = write-back system |
| cache_keep | input | 1 | 1 = caching stays enabled inside SMM |
| cfg_we | input | 1 | Load strobe for base and overlay |
| cfg_base | input | ADDR_W | New window base (low WIN_LSB bits ignored) |
| cfg_overlay | input | 1 | New overlay setting |
| smram_cs | output | 1 | SMM memory select |
| dram_cs | output | 1 | Main memory select |
| flush_n | output | 1 | Cache flush pulse, active low |
| ken_n | output | 1 | Cache enable, active low |
| wbwt | output | 1 | 1 = write-back allowed, 0 = force write-through |
| a20m_n | output | 1 | Gated address-bit-20 force, active low |

## Verification
The memory selects are combinational from the bus inputs and the configuration register, so they are sampled one time step after the inputs change. A base load is seen from the following cycle. Edge-driven results count the two synchroniser stages plus the edge register. `ken_n` and `wbwt` therefore move three edges after a status change, and `flush_n` falls at edge four because the request counter adds one stage. `a20m_n` tracks its request two edges late. The bench drives every input on a falling clock edge, counts rising edges with a step per falling edge, and samples exactly at the due step. It also samples the step before, which shows that nothing arrives early.

// File: rtl/smm_pkg.sv
package smm_pkg;

  // Synchronised status edges used by the sequencer.
  typedef struct packed {
    logic smi_fall;
    logic act_fall;
    logic act_rise;
  } smm_evt_t;

  function automatic logic [1:0] req_sum(input logic a, input logic b);
    return {1'b0, a} + {1'b0, b};
  endfunction

endpackage

// File: rtl/smm_sync.sv
module smm_sync #(
  parameter int              W       = 3,
  parameter logic [W-1:0]    RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic st1, st2;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st1 <= RST_VAL[i];
        st2 <= RST_VAL[i];
      end else begin
        st1 <= d[i];
        st2 <= st1;
      end
    end
    assign q[i] = st2;
  end
endmodule

// File: rtl/smm_decode.sv
module smm_decode #(
  parameter int ADDR_W  = 32,
  parameter int WIN_LSB = 15,
  parameter int MID_W   = 2,
  parameter int CPU_ID  = 0
) (
  input  logic                      cyc_stb,
  input  logic [ADDR_W-1:0]         cyc_addr,
  input  logic [MID_W-1:0]          cyc_mid,
  input  logic                      smiact_n,
  input  logic [ADDR_W-1:WIN_LSB]   base,
  input  logic                      overlay,
  output logic                      smram_cs,
  output logic                      dram_cs
);
  localparam logic [MID_W-1:0] CPU_MID = MID_W'(CPU_ID);

  logic hit, is_cpu, smm_ok;

  always_comb begin
    hit    = (cyc_addr[ADDR_W-1:WIN_LSB] == base);
    is_cpu = (cyc_mid == CPU_MID);
    smm_ok = hit && is_cpu && !smiact_n;
    smram_cs = 1'b0;
    dram_cs  = 1'b0;
    if (cyc_stb) begin
      if (smm_ok) begin
        smram_cs = 1'b1;
      end else if (!hit || overlay) begin
        dram_cs = 1'b1;
      end
    end
  end
endmodule

// File: rtl/smm_flush_pulse.sv
module smm_flush_pulse #(
  parameter int PEND_W = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] req_cnt,
  output logic       flush_n
);
  localparam int                SUM_W = PEND_W + 1;
  localparam logic [SUM_W-1:0]  MAXV  = SUM_W'((1 << PEND_W) - 1);

  logic [PEND_W-1:0] pend_q, pend_d;
  logic              pulse_q, pulse_d;
  logic              fire;
  logic [SUM_W-1:0]  sum;

  always_comb begin
    fire = (pend_q != '0) && !pulse_q;
    sum  = {1'b0, pend_q} + SUM_W'(req_cnt) - SUM_W'(fire);
    if (sum > MAXV) pend_d = MAXV[PEND_W-1:0];
    else            pend_d = sum[PEND_W-1:0];
    pulse_d = fire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= '0;
      pulse_q <= 1'b0;
    end else begin
      pend_q  <= pend_d;
      pulse_q <= pulse_d;
    end
  end

  assign flush_n = !pulse_q;
endmodule

// File: rtl/smm_steer.sv
module smm_steer #(
  parameter int                ADDR_W   = 32,
  parameter int                WIN_LSB  = 15,
  parameter int                MID_W    = 2,
  parameter int                CPU_ID   = 0,
  parameter int                PEND_W   = 2,
  parameter logic [ADDR_W-1:0] BASE_RST = 'h38000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smi_n,
  input  logic              smiact_n,
  input  logic              a20m_req_n,
  input  logic              cyc_stb,
  input  logic [ADDR_W-1:0] cyc_addr,
  input  logic [MID_W-1:0]  cyc_mid,
  input  logic              wb_mode,
  input  logic              cache_keep,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic              cfg_overlay,
  output logic              smram_cs,
  output logic              dram_cs,
  output logic              flush_n,
  output logic              ken_n,
  output logic              wbwt,
  output logic              a20m_n
);
  import smm_pkg::*;

  localparam int NSYNC = 3;

  // synchronised status: [2]=a20m, [1]=smiact, [0]=smi
  logic [NSYNC-1:0] s_now, s_dly_q;
  smm_evt_t         evt;

  smm_sync #(.W(NSYNC), .RST_VAL('1)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({a20m_req_n, smiact_n, smi_n}),
    .q     (s_now)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) s_dly_q <= '1;
    else        s_dly_q <= s_now;
  end

  always_comb begin
    evt.smi_fall = !s_now[0] &&  s_dly_q[0];
    evt.act_fall = !s_now[1] &&  s_dly_q[1];
    evt.act_rise =  s_now[1] && !s_dly_q[1];
  end

  // window configuration
  logic [ADDR_W-1:WIN_LSB] base_q, base_d;
  logic                    ovl_q, ovl_d;

  always_comb begin
    base_d = base_q;
    ovl_d  = ovl_q;
    if (cfg_we) begin
      base_d = cfg_base[ADDR_W-1:WIN_LSB];
      ovl_d  = cfg_overlay;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= BASE_RST[ADDR_W-1:WIN_LSB];
      ovl_q  <= 1'b1;
    end else begin
      base_q <= base_d;
      ovl_q  <= ovl_d;
    end
  end

  // SMM window flag: from entry trigger until status release
  logic win_q, win_d;

  always_comb begin
    win_d = win_q;
    if (evt.act_rise)                        win_d = 1'b0;
    else if (evt.act_fall || evt.smi_fall)   win_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) win_q <= 1'b0;
    else        win_q <= win_d;
  end

  // flush requests
  logic       entry_req, exit_req;
  logic [1:0] req_cnt;

  always_comb begin
    entry_req = ovl_q && (wb_mode ? evt.smi_fall : evt.act_fall);
    exit_req  = ovl_q && cache_keep && evt.act_rise;
    req_cnt   = req_sum(entry_req, exit_req);
  end

  smm_flush_pulse #(.PEND_W(PEND_W)) u_flush (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_cnt (req_cnt),
    .flush_n (flush_n)
  );

  smm_decode #(
    .ADDR_W (ADDR_W), .WIN_LSB(WIN_LSB), .MID_W(MID_W), .CPU_ID(CPU_ID)
  ) u_dec (
    .cyc_stb  (cyc_stb),
    .cyc_addr (cyc_addr),
    .cyc_mid  (cyc_mid),
    .smiact_n (smiact_n),
    .base     (base_q),
    .overlay  (ovl_q),
    .smram_cs (smram_cs),
    .dram_cs  (dram_cs)
  );

  always_comb begin
    ken_n  = win_q && !cache_keep;
    wbwt   = wb_mode && !win_q;
    a20m_n = s_now[2] || win_q || !s_now[1];
  end
endmodule

// File: rtl/smm_steer_chk.sv
module smm_steer_chk #(
  parameter int MID_W  = 2,
  parameter int CPU_ID = 0
) (
  input logic             clk,
  input logic             rst_n,
  input logic             smiact_n,
  input logic             cyc_stb,
  input logic [MID_W-1:0] cyc_mid,
  input logic             wb_mode,
  input logic             cache_keep,
  input logic             smram_cs,
  input logic             dram_cs,
  input logic             flush_n,
  input logic             ken_n,
  input logic             wbwt,
  input logic             a20m_n
);
  localparam logic [MID_W-1:0] CPU_MID = MID_W'(CPU_ID);

  p_cs_exclusive_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(smram_cs && dram_cs));

  p_other_master_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_stb && cyc_mid != CPU_MID) |-> !smram_cs);

  p_flush_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !flush_n |=> flush_n);

  p_ken_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ken_n |-> !cache_keep);

  p_wbwt_strap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !wb_mode |-> !wbwt);

  p_a20m_masked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(smiact_n, 1) && !$past(smiact_n, 2) && !$past(smiact_n, 3)) |-> a20m_n);
endmodule

bind smm_steer smm_steer_chk #(.MID_W(MID_W), .CPU_ID(CPU_ID)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .smiact_n   (smiact_n),
  .cyc_stb    (cyc_stb),
  .cyc_mid    (cyc_mid),
  .wb_mode    (wb_mode),
  .cache_keep (cache_keep),
  .smram_cs   (smram_cs),
  .dram_cs    (dram_cs),
  .flush_n    (flush_n),
  .ken_n      (ken_n),
  .wbwt       (wbwt),
  .a20m_n     (a20m_n)
);

// File: tb/smm_steer_tb.sv
`timescale 1ns/1ps
module smm_steer_tb;
  logic        clk, rst_n;
  logic        smi_n, smiact_n, a20m_req_n, cyc_stb;
  logic [31:0] cyc_addr, cfg_base;
  logic [1:0]  cyc_mid;
  logic        wb_mode, cache_keep, cfg_we, cfg_overlay;
  logic        smram_cs, dram_cs, flush_n, ken_n, wbwt, a20m_n;

  int n_chk = 0;
  int n_bad = 0;

  smm_steer u_dut (
    .clk(clk), .rst_n(rst_n), .smi_n(smi_n), .smiact_n(smiact_n),
    .a20m_req_n(a20m_req_n), .cyc_stb(cyc_stb), .cyc_addr(cyc_addr),
    .cyc_mid(cyc_mid), .wb_mode(wb_mode), .cache_keep(cache_keep),
    .cfg_we(cfg_we), .cfg_base(cfg_base), .cfg_overlay(cfg_overlay),
    .smram_cs(smram_cs), .dram_cs(dram_cs), .flush_n(flush_n),
    .ken_n(ken_n), .wbwt(wbwt), .a20m_n(a20m_n)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // {mid[1:0], smiact_n, stb, addr[31:0], exp_smram, exp_dram}
  localparam logic [37:0] DEC_TAB [8] = '{
    {2'd0, 1'b0, 1'b1, 32'h0003_8000, 1'b1, 1'b0},  // R2 CPU in SMM
    {2'd0, 1'b1, 1'b1, 32'h0003_8000, 1'b0, 1'b1},  // R2 CPU outside SMM
    {2'd0, 1'b0, 1'b1, 32'h0003_FFFF, 1'b1, 1'b0},  // R2 top of window
    {2'd0, 1'b0, 1'b1, 32'h0004_0000, 1'b0, 1'b1},  // R2 above window
    {2'd0, 1'b0, 1'b1, 32'h0003_7FFF, 1'b0, 1'b1},  // R2 below window
    {2'd1, 1'b0, 1'b1, 32'h0003_8010, 1'b0, 1'b1},  // R3 other master
    {2'd0, 1'b0, 1'b0, 32'h0003_8000, 1'b0, 1'b0},  // R2 no strobe
    {2'd3, 1'b1, 1'b1, 32'h0003_A000, 1'b0, 1'b1}   // R3 other master
  };

  task automatic step(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic dec(input logic [1:0] mid, input logic sa, input logic [31:0] a,
                     input logic es, input logic ed, input string tag);
    cyc_mid = mid; smiact_n = sa; cyc_stb = 1'b1; cyc_addr = a;
    #1;
    chk(tag, {smram_cs, dram_cs}, {es, ed});
  endtask

  // watch flush over n steps; returns 1 if any low seen
  task automatic watch_flush(input int n, output logic seen);
    seen = 1'b0;
    for (int i = 0; i < n; i++) begin
      step();
      if (!flush_n) seen = 1'b1;
    end
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic seen;
    rst_n = 1'b0; smi_n = 1'b1; smiact_n = 1'b1; a20m_req_n = 1'b1;
    cyc_stb = 1'b0; cyc_addr = '0; cyc_mid = '0; wb_mode = 1'b0;
    cache_keep = 1'b1; cfg_we = 1'b0; cfg_base = '0; cfg_overlay = 1'b1;
    step(3);
    rst_n = 1'b1;
    step();
    // R1 reset state
    chk("R1 flush_n", flush_n, 1);
    chk("R1 ken_n", ken_n, 0);
    chk("R1 a20m_n", a20m_n, 1);
    chk("R1 wbwt", wbwt, 0);

    // decode table
    for (int i = 0; i < 8; i++) begin
      cyc_mid  = DEC_TAB[i][37:36];
      smiact_n = DEC_TAB[i][35];
      cyc_stb  = DEC_TAB[i][34];
      cyc_addr = DEC_TAB[i][33:2];
      #1;
      chk($sformatf("R2/R3 decode row %0d", i), {smram_cs, dram_cs}, DEC_TAB[i][1:0]);
      step();
    end
    smiact_n = 1'b1; cyc_stb = 1'b0;
    step(14);

    // R4 entry flush in write-through mode
    smiact_n = 1'b0;
    step(3); chk("R4 no early flush", flush_n, 1);
    step();  chk("R4 entry flush low", flush_n, 0);
    step();  chk("R4 flush one cycle", flush_n, 1);
    step(4);
    // R5 exit flush with cache kept
    smiact_n = 1'b1;
    step(3); chk("R5 no early flush", flush_n, 1);
    step();  chk("R5 exit flush low", flush_n, 0);
    step();  chk("R5 flush one cycle", flush_n, 1);
    step(4);

    // R6 cache disabled in SMM, no exit flush
    cache_keep = 1'b0;
    smiact_n = 1'b0;
    step(2); chk("R6 ken before", ken_n, 0);
    step();  chk("R6 ken high", ken_n, 1);
    step(5);
    smiact_n = 1'b1;
    step(2); chk("R6 ken still high", ken_n, 1);
    step();  chk("R6 ken released", ken_n, 0);
    watch_flush(6, seen);
    chk("R6 no exit flush", seen, 0);
    cache_keep = 1'b1;

    // R10 back-to-back requests
    smiact_n = 1'b0;
    step(); smiact_n = 1'b1;
    step(3); chk("R10 first pulse", flush_n, 0);
    step();  chk("R10 gap", flush_n, 1);
    step();  chk("R10 second pulse", flush_n, 0);
    step();  chk("R10 after second", flush_n, 1);
    step(4);

    // R7 write-back mode
    wb_mode = 1'b1;
    step();  chk("R7 wbwt idle", wbwt, 1);
    smi_n = 1'b0;
    step(2); chk("R7 wbwt before", wbwt, 1);
    step();  chk("R7 wbwt forced", wbwt, 0);
    step();  chk("R7 flush with smi", flush_n, 0);
    smi_n = 1'b1;
    step(2);
    smiact_n = 1'b0;
    watch_flush(6, seen);
    chk("R7 no flush on smiact", seen, 0);
    smiact_n = 1'b1;
    step(3); chk("R7 wbwt restored", wbwt, 1);
    step(4);
    wb_mode = 1'b0;
    step(2);

    // R8 A20 mask
    a20m_req_n = 1'b0;
    step();  chk("R8 a20m latency", a20m_n, 1);
    step();  chk("R8 a20m follows", a20m_n, 0);
    smiact_n = 1'b0;
    step(2); chk("R8 a20m blocked", a20m_n, 1);
    step(4);
    smiact_n = 1'b1;
    step(2); chk("R8 a20m still blocked", a20m_n, 1);
    step();  chk("R8 a20m restored", a20m_n, 0);
    a20m_req_n = 1'b1;
    step(6);

    // R9 non-overlaid
    cfg_we = 1'b1; cfg_base = 32'h0003_8000; cfg_overlay = 1'b0;
    step(); cfg_we = 1'b0;
    dec(2'd0, 1'b0, 32'h0003_8100, 1'b1, 1'b0, "R9 cpu smm hit");
    dec(2'd2, 1'b0, 32'h0003_8100, 1'b0, 1'b0, "R9 other master hit");
    dec(2'd0, 1'b1, 32'h0003_8100, 1'b0, 1'b0, "R9 cpu normal hit");
    dec(2'd0, 1'b1, 32'h0001_0000, 1'b0, 1'b1, "R9 outside");
    cyc_stb = 1'b0;
    smiact_n = 1'b0;
    watch_flush(6, seen);
    smiact_n = 1'b1;
    begin
      logic seen2;
      watch_flush(6, seen2);
      chk("R9 no flush", seen | seen2, 0);
    end

    // R11 base load timing
    cfg_we = 1'b1; cfg_base = 32'h0005_0000; cfg_overlay = 1'b1;
    dec(2'd0, 1'b0, 32'h0005_0000, 1'b0, 1'b1, "R11 before load");
    step(); cfg_we = 1'b0;
    dec(2'd0, 1'b0, 32'h0005_0000, 1'b1, 1'b0, "R11 new base");
    dec(2'd0, 1'b0, 32'h0003_8000, 1'b0, 1'b1, "R11 old base");
    cyc_stb = 1'b0; smiact_n = 1'b1;
    step(10);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule